// File: doc/BRIEF.md
# Minimal 32-bit Load-Store Processor Core

This block is a single-cycle processor core that executes a compact, fixed-length 32-bit instruction set of eight operations: register add, register nand, add-immediate, word load, word store, branch-if-equal, jump-and-link through registers, and halt. Each instruction carries a 4-bit opcode in bits 31-28, a first register field X in bits 27-24, a second register field Y in bits 23-20, and either a third register field Z in bits 3-0 or a 20-bit two's-complement immediate in bits 19-0. Sixteen 32-bit registers are held internally, with register 0 hard-wired to zero.

The core fetches one instruction per clock from a word-addressed instruction port and uses a word-addressed data port for loads and stores. Both ports present an address combinationally and return read data within the same cycle; a store is committed by the memory at the rising clock edge while the write strobe is high. Every address is a word address, so sequential execution advances the program counter by one. When a halt instruction retires, the core raises its halted output and stops executing for good, until the next reset.

Top module: `ls_core32`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and just after its release, the instruction address is 0, halted is 0, and every register reads as 0.
- R2: Opcode 0 (add) writes rY + rZ into rX and opcode 1 (nand) writes the bitwise inverse of (rY AND rZ) into rX, Z being bits 3-0; bits 19-4 have no effect on the result.
- R3: Opcode 2 (addi) writes rY plus the sign-extended 20-bit immediate from bits 19-0 into rX.
- R4: Opcode 3 (load) writes the data word at address rY + sext(imm) into rX; opcode 4 (store) drives that address with the write strobe high and rX on the write data for exactly that cycle; no other instruction raises the strobe.
- R5: Register 0 reads as zero at all times; an instruction that targets register 0 leaves it zero.
- R6: After add, nand, addi, load, store, or any opcode from 8 to 15, the next instruction address is the current one plus 1; opcodes 8 to 15 change no register and no memory word.
- R7: Opcode 5 (beq) sets the next address to current + 1 + sext(imm) when rX equals rY, and to current + 1 otherwise; negative offsets branch backwards.
- R8: Opcode 6 (jalr) sets the next address to the value of rX and writes current address + 1 into rY; when X and Y name the same register, the jump uses the value held before the write.
- R9: Opcode 7 (halt) raises halted from the following cycle onward; while halted the instruction address stays on the halt instruction, the store strobe stays low and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Word address of the instruction to fetch (program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Word address for load or store |
| dmem_rdata | input | 32 | Data word at dmem_addr, same cycle |
| dmem_we | output | 1 | Store strobe, committed at the rising edge |
| dmem_wdata | output | 32 | Word to store |
| halted | output | 1 | High once a halt instruction has retired |

## Verification
The program exercises a branch that is taken forwards, one that falls through and a backward loop branch; a core that added the offset to the unincremented address or ignored its sign would fetch the wrong word on the next cycle. A jump-and-link whose target and link registers coincide catches a core that jumps to the freshly written link value, and a load with a negative offset catches a missing sign extension in the effective address. Writes aimed at register 0, garbage in the unused R-type bits and an undefined opcode go after decode that leaks into state, and a store placed right after the halt catches a core that keeps running or keeps strobing memory once halted.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   localparam int INSN_W  = 32;
   localparam int OP_W    = 4;
   localparam int RIDX_W  = 4;
   localparam int IMM_W   = 20;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_NAND = 4'd1,
      OP_ADDI = 4'd2,
      OP_LW   = 4'd3,
      OP_SW   = 4'd4,
      OP_BEQ  = 4'd5,
      OP_JALR = 4'd6,
      OP_HALT = 4'd7
   } op_e;

   typedef struct packed {
      logic [OP_W-1:0]   op;
      logic [RIDX_W-1:0] rx;
      logic [RIDX_W-1:0] ry;
      logic [IMM_W-1:0]  low;
   } insn_t;

endpackage

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
   parameter int XLEN      = 32,
   parameter int NREG      = 16,
   parameter int NRD       = 3,
   parameter bit RST_CLEAR = 1'b1,
   localparam int RIDX_W   = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RIDX_W-1:0] ra [NRD],
   output logic [XLEN-1:0]   rd [NRD],
   input  logic              we,
   input  logic [RIDX_W-1:0] wa,
   input  logic [XLEN-1:0]   wd
);

   initial begin
      if (NREG < 2 || (1 << RIDX_W) != NREG)
         $error("lsc_regfile: NREG must be a power of two");
      if (NRD < 1)
         $error("lsc_regfile: at least one read port needed");
   end

   logic [XLEN-1:0] regs [NREG];
   logic            wr_live;

   assign wr_live = we && (wa != '0);

   generate
      if (RST_CLEAR) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NREG; i++) regs[i] <= '0;
            end else if (wr_live) begin
               regs[wa] <= wd;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (wr_live) regs[wa] <= wd;
         end
      end
   endgenerate

   generate
      for (genvar g = 0; g < NRD; g++) begin : g_rd
         assign rd[g] = (ra[g] == '0) ? '0 : regs[ra[g]];
      end
   endgenerate

   // R2
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/lsc_exec.sv
module lsc_exec
   import lsc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [INSN_W-1:0] insn,
   input  logic [XLEN-1:0]   pc,
   input  logic [XLEN-1:0]   val_x,
   input  logic [XLEN-1:0]   val_y,
   input  logic [XLEN-1:0]   val_z,
   input  logic [XLEN-1:0]   ld_data,
   output op_e               op,
   output logic [RIDX_W-1:0] sel_x,
   output logic [RIDX_W-1:0] sel_y,
   output logic [RIDX_W-1:0] sel_z,
   output logic              wr_en,
   output logic [RIDX_W-1:0] wr_sel,
   output logic [XLEN-1:0]   wr_val,
   output logic [XLEN-1:0]   pc_next,
   output logic [XLEN-1:0]   mem_addr,
   output logic              mem_store,
   output logic              stop
);

   initial begin
      if (XLEN < IMM_W) $error("lsc_exec: XLEN narrower than immediate");
   end

   insn_t           f;
   logic [XLEN-1:0] imm_s;
   logic [XLEN-1:0] pc_inc;
   logic            same;

   assign f      = insn_t'(insn);
   assign op     = op_e'(f.op);
   assign sel_x  = f.rx;
   assign sel_y  = f.ry;
   assign sel_z  = f.low[RIDX_W-1:0];
   assign imm_s  = {{(XLEN-IMM_W){f.low[IMM_W-1]}}, f.low};
   assign pc_inc = pc + 1'b1;
   assign same   = (val_x == val_y);

   assign mem_addr  = val_y + imm_s;
   assign mem_store = (op == OP_SW);
   assign stop      = (op == OP_HALT);

   always_comb begin
      wr_en  = 1'b0;
      wr_sel = f.rx;
      wr_val = '0;
      unique case (op)
         OP_ADD:  begin wr_en = 1'b1; wr_val = val_y + val_z;      end
         OP_NAND: begin wr_en = 1'b1; wr_val = ~(val_y & val_z);   end
         OP_ADDI: begin wr_en = 1'b1; wr_val = val_y + imm_s;      end
         OP_LW:   begin wr_en = 1'b1; wr_val = ld_data;            end
         OP_JALR: begin wr_en = 1'b1; wr_val = pc_inc; wr_sel = f.ry; end
         default: ;
      endcase
   end

   always_comb begin
      unique case (op)
         OP_BEQ:  pc_next = same ? pc_inc + imm_s : pc_inc;
         OP_JALR: pc_next = val_x;
         OP_HALT: pc_next = pc;
         default: pc_next = pc_inc;
      endcase
   end

endmodule

// File: rtl/ls_core32.sv
module ls_core32
   import lsc_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int NREG      = 16,
   parameter bit RST_CLEAR = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] imem_addr,
   input  logic [XLEN-1:0] imem_rdata,
   output logic [XLEN-1:0] dmem_addr,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic            dmem_we,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            halted
);

   localparam int NRD = 3;

   initial begin
      if (XLEN != INSN_W) $error("ls_core32: XLEN must equal instruction width");
      if ($clog2(NREG) != RIDX_W) $error("ls_core32: NREG must match register field");
   end

   logic [XLEN-1:0]   pc_q;
   logic              halt_q;
   op_e               op;
   logic [RIDX_W-1:0] sel_x, sel_y, sel_z, wr_sel;
   logic [RIDX_W-1:0] ra [NRD];
   logic [XLEN-1:0]   rd [NRD];
   logic              wr_en, mem_store, stop;
   logic [XLEN-1:0]   wr_val, pc_next;

   assign ra[0] = sel_x;
   assign ra[1] = sel_y;
   assign ra[2] = sel_z;

   lsc_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD), .RST_CLEAR(RST_CLEAR)) u_rf (
      .clk(clk), .rst_n(rst_n), .ra(ra), .rd(rd),
      .we(wr_en && !halt_q), .wa(wr_sel), .wd(wr_val)
   );

   lsc_exec #(.XLEN(XLEN)) u_ex (
      .insn(imem_rdata), .pc(pc_q),
      .val_x(rd[0]), .val_y(rd[1]), .val_z(rd[2]), .ld_data(dmem_rdata),
      .op(op), .sel_x(sel_x), .sel_y(sel_y), .sel_z(sel_z),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val), .pc_next(pc_next),
      .mem_addr(dmem_addr), .mem_store(mem_store), .stop(stop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         halt_q <= 1'b0;
      end else if (!halt_q) begin
         pc_q   <= pc_next;
         halt_q <= stop;
      end
   end

   assign imem_addr  = pc_q;
   assign halted     = halt_q;
   assign dmem_we    = mem_store && !halt_q;
   assign dmem_wdata = rd[0];

   // R9
   halted_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R9
   pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(imem_addr));

   // R6
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && op != OP_BEQ && op != OP_JALR && op != OP_HALT)
      |=> (imem_addr == $past(imem_addr) + 1));

   // R7
   beq_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && op == OP_BEQ && rd[0] == rd[1])
      |=> (imem_addr == $past(imem_addr) + 1
           + {{(XLEN-IMM_W){$past(imem_rdata[IMM_W-1])}}, $past(imem_rdata[IMM_W-1:0])}));

   // R8
   jalr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && op == OP_JALR) |=> (imem_addr == $past(rd[0])));

endmodule

// File: tb/sim_ls_core32.sv
module sim_ls_core32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata, dmem_wdata;
   logic        dmem_we, halted;

   logic [31:0] imem [64];
   logic [31:0] dmem [64];
   logic [31:0] mdmem [64];
   logic [31:0] mr [16];
   logic [31:0] mpc;
   logic        mhalt;
   logic [3:0]  mlast;
   int          n_chk = 0;
   int          n_bad = 0;

   always #10 clk = ~clk;

   ls_core32 u0 (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_we(dmem_we),
      .dmem_wdata(dmem_wdata), .halted(halted)
   );

   assign imem_rdata = imem[imem_addr[5:0]];
   assign dmem_rdata = dmem[dmem_addr[5:0]];

   always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;

   function automatic logic [31:0] ei(input int op, input int x, input int y, input int imm);
      logic [31:0] v;
      v = imm;
      return {op[3:0], x[3:0], y[3:0], v[19:0]};
   endfunction

   function automatic logic [31:0] er(input int op, input int x, input int y, input int z, input int junk);
      logic [31:0] j;
      j = junk;
      return {op[3:0], x[3:0], y[3:0], j[15:0], z[3:0]};
   endfunction

   function automatic logic [31:0] sx(input logic [31:0] w);
      return {{12{w[19]}}, w[19:0]};
   endfunction

   function automatic string pc_tag(input logic [3:0] op);
      case (op)
         4'd5:    return "R7";
         4'd6:    return "R8";
         4'd7:    return "R9";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // behavioural reference, stepped on each rising edge
   logic [31:0] t_ins, t_y, t_x, t_z, t_imm;
   logic [3:0]  t_op;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mpc <= 0;
         mhalt <= 0;
         mlast <= 4'd0;
         for (int i = 0; i < 16; i++) mr[i] <= 0;
      end else if (!mhalt) begin
         t_ins = imem[mpc[5:0]];
         t_op  = t_ins[31:28];
         t_x   = mr[t_ins[27:24]];
         t_y   = mr[t_ins[23:20]];
         t_z   = mr[t_ins[3:0]];
         t_imm = sx(t_ins);
         mlast <= t_op;
         mpc <= mpc + 1;
         case (t_op)
            4'd0: if (t_ins[27:24] != 0) mr[t_ins[27:24]] <= t_y + t_z;
            4'd1: if (t_ins[27:24] != 0) mr[t_ins[27:24]] <= ~(t_y & t_z);
            4'd2: if (t_ins[27:24] != 0) mr[t_ins[27:24]] <= t_y + t_imm;
            4'd3: if (t_ins[27:24] != 0) mr[t_ins[27:24]] <= mdmem[(t_y + t_imm) & 63];
            4'd4: mdmem[(t_y + t_imm) & 63] <= t_x;
            4'd5: if (t_x == t_y) mpc <= mpc + 1 + t_imm;
            4'd6: begin
               if (t_ins[23:20] != 0) mr[t_ins[23:20]] <= mpc + 1;
               mpc <= t_x;
            end
            4'd7: begin mhalt <= 1; mpc <= mpc; end
            default: ;
         endcase
      end
   end

   // compare outputs with the reference in the middle of each cycle
   logic        running = 1'b0;
   logic [31:0] c_ins;
   always @(negedge clk) begin
      if (rst_n && running) begin
         c_ins = imem[mpc[5:0]];
         check(pc_tag(mlast), "instruction address", imem_addr, mpc);
         check("R9", "halted", {31'd0, halted}, {31'd0, mhalt});
         check("R4", "store strobe", {31'd0, dmem_we},
               {31'd0, (!mhalt && c_ins[31:28] == 4'd4)});
         if (!mhalt && c_ins[31:28] == 4'd4) begin
            check("R4", "store address", dmem_addr, mr[c_ins[23:20]] + sx(c_ins));
            check("R4", "store data", dmem_wdata, mr[c_ins[27:24]]);
         end
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         imem[i] = 32'h0;
         dmem[i] = 32'h0;
         mdmem[i] = 32'h0;
      end
      dmem[4]  = 32'h12345678;
      mdmem[4] = 32'h12345678;
      imem[0]  = ei(2, 1, 0, 5);
      imem[1]  = ei(2, 2, 0, -3);
      imem[2]  = er(0, 3, 1, 2, 16'hABC);
      imem[3]  = er(1, 4, 1, 2, 16'h5A5);
      imem[4]  = ei(2, 0, 1, 7);
      imem[5]  = ei(4, 3, 0, 10);
      imem[6]  = ei(4, 4, 1, 3);
      imem[7]  = ei(3, 5, 0, 10);
      imem[8]  = er(0, 6, 5, 0, 0);
      imem[9]  = ei(4, 0, 0, 11);
      imem[10] = ei(5, 1, 2, 5);
      imem[11] = ei(5, 3, 5, 2);
      imem[12] = ei(2, 7, 0, 99);
      imem[13] = ei(2, 7, 0, 98);
      imem[14] = ei(2, 8, 0, 20);
      imem[15] = ei(6, 8, 9, 0);
      imem[20] = ei(4, 9, 0, 12);
      imem[21] = ei(2, 10, 0, 24);
      imem[22] = ei(6, 10, 10, 0);
      imem[23] = ei(2, 7, 0, 97);
      imem[24] = ei(4, 10, 0, 13);
      imem[25] = 32'h9ABCDEF1;
      imem[26] = ei(2, 11, 11, 1);
      imem[27] = ei(5, 11, 1, 1);
      imem[28] = ei(5, 0, 0, -3);
      imem[29] = ei(4, 11, 0, 14);
      imem[30] = ei(3, 13, 1, -1);
      imem[31] = ei(4, 13, 0, 15);
      imem[32] = ei(4, 2, 0, 9);
      imem[33] = ei(7, 0, 0, 0);
      imem[34] = ei(4, 1, 0, 16);

      repeat (2) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1", "address in reset", imem_addr, 32'd0);
      check("R1", "halted in reset", {31'd0, halted}, 32'd0);
      check("R1", "strobe in reset", {31'd0, dmem_we}, 32'd0);
      rst_n = 1'b1;
      running = 1'b1;
      // R1 / R5: register 0 and cleared registers feed the first addi
      check("R1", "first address after release", imem_addr, 32'd0);

      begin : run
         for (int cyc = 0; cyc < 500; cyc++) begin
            @(negedge clk);
            if (halted) disable run;
         end
         n_chk++;
         n_bad++;
         $display("FAIL R9 watchdog: actual not halted expected halted");
      end
      repeat (6) @(negedge clk);
      #1;
      running = 1'b0;

      check("R2", "add result", dmem[10], 32'd2);
      check("R2", "nand result", dmem[8], 32'hFFFFFFFA);
      check("R3", "negative immediate", dmem[9], 32'hFFFFFFFD);
      check("R5", "register 0 after write attempt", dmem[11], 32'd0);
      check("R8", "link register", dmem[12], 32'd16);
      check("R8", "same-register jalr link", dmem[13], 32'd23);
      check("R7", "backward loop count", dmem[14], 32'd5);
      check("R4", "load with negative offset", dmem[15], 32'h12345678);
      check("R9", "store after halt suppressed", dmem[16], 32'd0);
      check("R9", "address held on halt", imem_addr, 32'd33);
      begin
         int diff = 0;
         for (int i = 0; i < 64; i++) if (dmem[i] !== mdmem[i]) diff++;
         check("R6", "memory image mismatches", diff, 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule